// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Controller

This block turns a clocked single-request port into the strobe sequences of an external asynchronous static RAM that is 8 bits wide and has a 21-bit word address. A request carries a read/write flag, an address and a write byte. It is accepted on a valid/ready handshake. Read data returns on a response port with a one-clock valid flag. Only one access is in flight at a time. Nanosecond minimums are given as picosecond parameters and turned into clock-cycle counts, rounded up, using the clock period parameter.

The memory has two chip enables of opposite polarity. It counts as selected only when the low-true enable is 0 and the high-true enable is 1. Writes are ended by write enable. Output enable stays low through them. Because of that, the controller waits for the memory's output turn-off time after write enable falls, and only then drives the data bus. The data bus is split into an output, an output-enable and an input, for a pad cell outside the block. After reset, every access is held off for a power-up interval.

Top module: `sram_ctrl`

## Requirements
- R1: The memory is selected only by mem_ce_n_o=0 together with mem_ce_o=1. While idle, during power-up and during reset the controller drives mem_ce_n_o=1 and mem_ce_o=0.
- R2: After reset is released, req_ready_o stays 0 and the memory stays deselected for exactly PWR_CYC = ceil(T_PWR_PS/CLK_PS) clocks. After that, req_ready_o is 1.
- R3: A write has three phases. First, ADDR_CYC clocks selected with mem_we_n_o=1. Then TURN_CYC clocks with mem_we_n_o=0 and the bus released. Then DATA_CYC clocks with mem_we_n_o=0 and the bus driven. mem_oe_n_o stays 0 throughout. req_ready_o returns ADDR_CYC+TURN_CYC+DATA_CYC clocks after acceptance.
- R4: mem_dq_oe_o is 1 only while the memory is selected with mem_we_n_o=0, and only after write enable has been low for at least TURN_CYC = ceil(T_TURN_PS/CLK_PS) clocks. It is driven for at least DATA_CYC = max(ceil(T_SETUP_PS/CLK_PS), ceil(T_WE_PS/CLK_PS)-TURN_CYC, 1) clocks before write enable rises, and it drops on the same edge.
- R5: The byte written to an address is the byte a later read of that address returns.
- R6: A read keeps the memory selected with mem_oe_n_o=0 and mem_we_n_o=1 for RD_CYC = ceil(T_ACC_PS/CLK_PS)+SYNC_CYC clocks. It then samples mem_dq_i into rsp_rdata_o. rsp_valid_o is 1 for exactly one clock, RD_CYC clocks after acceptance.
- R7: mem_addr_o stays constant for as long as the memory is selected during one access.
- R8: req_ready_o drops on the clock after a request is accepted. It stays 0 until the access ends, so only one access is ever outstanding.
- R9: Asserting rst_ni during an access deselects the memory, forces mem_we_n_o=1, releases the bus, drops req_ready_o and restarts the power-up interval. An access aborted before write enable falls leaves the memory contents unchanged.
- R10: Addresses 0 and 2^21-1 are both written and read correctly over the full 21-bit bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 21 | Word address |
| req_wdata_i | input | 8 | Write byte |
| rsp_valid_o | output | 1 | Read data valid, one clock |
| rsp_rdata_o | output | 8 | Read data |
| mem_ce_n_o | output | 1 | Memory enable, active low |
| mem_ce_o | output | 1 | Memory enable, active high |
| mem_we_n_o | output | 1 | Memory write enable, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_addr_o | output | 21 | Memory address |
| mem_dq_o | output | 8 | Data bus drive value |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | 8 | Data bus sampled value |

## Verification
The hardest cases to reach are the edges where one access ends and the next begins: a write's write-enable rise and bus release on the same clock, followed at once by an accepted read, with no idle cycle between them. The bench gets there by issuing randomly mixed reads and writes over a small address pool, with gaps of zero to three cycles. A bus model commits each write only at the cycle where the write ends. A reset is also fired one clock into a write, before write enable falls. The bench then reads the same location back after the new power-up interval.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_IDLE,
    ST_WADDR,
    ST_WTURN,
    ST_WDATA,
    ST_RWAIT
  } st_e;

  function automatic int cdiv(input longint num, input longint den);
    return int'((num + den - 1) / den);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int W       = 4,
  parameter int RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= W'(RST_VAL);
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CW       = 4,
  parameter int ADDR_CYC = 1,
  parameter int TURN_CYC = 1,
  parameter int DATA_CYC = 1,
  parameter int RD_CYC   = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic          pwr_done_i,
  input  logic          ph_done_i,
  output st_e           st_o,
  output st_e           st_n_o,
  output logic          ld_o,
  output logic [CW-1:0] ld_val_o,
  output logic          accept_o,
  output logic          capture_o
);
  st_e st_q, st_n;

  always_comb begin
    st_n      = st_q;
    ld_o      = 1'b0;
    ld_val_o  = '0;
    accept_o  = 1'b0;
    capture_o = 1'b0;
    unique case (st_q)
      ST_PWR: if (pwr_done_i) st_n = ST_IDLE;
      ST_IDLE: begin
        if (req_valid_i) begin
          accept_o = 1'b1;
          ld_o     = 1'b1;
          if (req_write_i) begin
            st_n     = ST_WADDR;
            ld_val_o = CW'(ADDR_CYC - 1);
          end else begin
            st_n     = ST_RWAIT;
            ld_val_o = CW'(RD_CYC - 1);
          end
        end
      end
      ST_WADDR: if (ph_done_i) begin
        st_n     = ST_WTURN;
        ld_o     = 1'b1;
        ld_val_o = CW'(TURN_CYC - 1);
      end
      ST_WTURN: if (ph_done_i) begin
        st_n     = ST_WDATA;
        ld_o     = 1'b1;
        ld_val_o = CW'(DATA_CYC - 1);
      end
      ST_WDATA: if (ph_done_i) st_n = ST_IDLE;
      ST_RWAIT: if (ph_done_i) begin
        st_n      = ST_IDLE;
        capture_o = 1'b1;
      end
      default: st_n = ST_PWR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_PWR;
    else         st_q <= st_n;
  end

  assign st_o   = st_q;
  assign st_n_o = st_n;
endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp
  import sram_ctrl_pkg::*;
#(
  parameter int AW = 21,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  st_e           st_n_i,
  input  logic          accept_i,
  input  logic          capture_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          mem_ce_n_o,
  output logic          mem_ce_o,
  output logic          mem_we_n_o,
  output logic          mem_oe_n_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);
  logic sel_n, we_n, oe_n, drv_n;

  // pin levels decoded from the next state, then registered
  always_comb begin
    sel_n = (st_n_i == ST_WADDR) || (st_n_i == ST_WTURN) ||
            (st_n_i == ST_WDATA) || (st_n_i == ST_RWAIT);
    we_n  = !((st_n_i == ST_WTURN) || (st_n_i == ST_WDATA));
    oe_n  = (st_n_i == ST_PWR);
    drv_n = (st_n_i == ST_WDATA);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_ce_n_o  <= 1'b1;
      mem_ce_o    <= 1'b0;
      mem_we_n_o  <= 1'b1;
      mem_oe_n_o  <= 1'b1;
      mem_dq_oe_o <= 1'b0;
    end else begin
      mem_ce_n_o  <= !sel_n;
      mem_ce_o    <= sel_n;
      mem_we_n_o  <= we_n;
      mem_oe_n_o  <= oe_n;
      mem_dq_oe_o <= drv_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o <= '0;
      mem_dq_o   <= '0;
    end else if (accept_i) begin
      mem_addr_o <= req_addr_i;
      mem_dq_o   <= req_wdata_i;
    end
  end

  // bus input is asynchronous; sampled only after the wait count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= capture_i;
      if (capture_i) rsp_rdata_o <= mem_dq_i;
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW         = 21,
  parameter int DW         = 8,
  parameter int CLK_PS     = 10000,
  parameter int T_PWR_PS   = 1000000000,
  parameter int T_WE_PS    = 7000,
  parameter int T_WC_PS    = 10000,
  parameter int T_SETUP_PS = 5500,
  parameter int T_TURN_PS  = 5000,
  parameter int T_ACC_PS   = 10000,
  parameter int ADDR_CYC   = 1,
  parameter int SYNC_CYC   = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          mem_ce_n_o,
  output logic          mem_ce_o,
  output logic          mem_we_n_o,
  output logic          mem_oe_n_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);
  localparam int TURN_CYC = imax(cdiv(T_TURN_PS, CLK_PS), 1);
  localparam int PWE_CYC  = cdiv(T_WE_PS, CLK_PS);
  localparam int WC_CYC   = cdiv(T_WC_PS, CLK_PS);
  localparam int DATA_CYC = imax(imax(cdiv(T_SETUP_PS, CLK_PS), PWE_CYC - TURN_CYC),
                                 imax(WC_CYC - ADDR_CYC - TURN_CYC, 1));
  localparam int RD_CYC   = cdiv(T_ACC_PS, CLK_PS) + SYNC_CYC;
  localparam int PWR_CYC  = imax(cdiv(T_PWR_PS, CLK_PS), 1);
  localparam int PH_MAX   = imax(imax(ADDR_CYC, TURN_CYC), imax(DATA_CYC, RD_CYC));
  localparam int CW       = $clog2(PH_MAX + 1);
  localparam int PW       = $clog2(PWR_CYC + 1);

  st_e           st, st_n;
  logic          ld, accept, capture, ph_done, pwr_done;
  logic [CW-1:0] ld_val;

  sram_ctrl_timer #(.W(PW), .RST_VAL(PWR_CYC - 1)) u_pwr_tmr (
    .clk_i, .rst_ni, .load_i(1'b0), .val_i('0), .done_o(pwr_done)
  );

  sram_ctrl_timer #(.W(CW), .RST_VAL(0)) u_ph_tmr (
    .clk_i, .rst_ni, .load_i(ld), .val_i(ld_val), .done_o(ph_done)
  );

  sram_ctrl_fsm #(
    .CW(CW), .ADDR_CYC(ADDR_CYC), .TURN_CYC(TURN_CYC),
    .DATA_CYC(DATA_CYC), .RD_CYC(RD_CYC)
  ) u_fsm (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i,
    .pwr_done_i(pwr_done), .ph_done_i(ph_done),
    .st_o(st), .st_n_o(st_n), .ld_o(ld), .ld_val_o(ld_val),
    .accept_o(accept), .capture_o(capture)
  );

  sram_ctrl_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk_i, .rst_ni, .st_n_i(st_n), .accept_i(accept), .capture_i(capture),
    .req_addr_i, .req_wdata_i, .rsp_valid_o, .rsp_rdata_o,
    .mem_ce_n_o, .mem_ce_o, .mem_we_n_o, .mem_oe_n_o, .mem_addr_o,
    .mem_dq_o, .mem_dq_oe_o, .mem_dq_i
  );

  assign req_ready_o = (st == ST_IDLE);
endmodule

// File: rtl/sram_ctrl_sva.sv
module sram_ctrl_sva #(
  parameter int AW       = 21,
  parameter int TURN_CYC = 1,
  parameter int PWR_CYC  = 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          rsp_valid_o,
  input logic          mem_ce_n_o,
  input logic          mem_ce_o,
  input logic          mem_we_n_o,
  input logic          mem_oe_n_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_dq_oe_o
);
  logic        sel;
  logic [31:0] up_cnt, we_low_cnt;

  assign sel = !mem_ce_n_o && mem_ce_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_cnt     <= '0;
      we_low_cnt <= '0;
    end else begin
      if (up_cnt != '1) up_cnt <= up_cnt + 1'b1;
      we_low_cnt <= mem_we_n_o ? '0 : we_low_cnt + 1'b1;
    end
  end

  p_pwr_lock_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_cnt < 32'(PWR_CYC)) |-> (!req_ready_o && !sel));

  p_we_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> (sel && !mem_oe_n_o));

  p_bus_we_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (!mem_we_n_o && sel));

  p_turn_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> (we_low_cnt >= 32'(TURN_CYC)));

  p_rsp_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_addr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && $past(sel)) |-> $stable(mem_addr_o));

  p_one_out_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
endmodule

bind sram_ctrl sram_ctrl_sva #(.AW(AW), .TURN_CYC(TURN_CYC), .PWR_CYC(PWR_CYC)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o),
  .mem_ce_n_o(mem_ce_n_o), .mem_ce_o(mem_ce_o), .mem_we_n_o(mem_we_n_o),
  .mem_oe_n_o(mem_oe_n_o), .mem_addr_o(mem_addr_o), .mem_dq_oe_o(mem_dq_oe_o)
);

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sram_ctrl;
  localparam int AW = 21;
  localparam int DW = 8;
  localparam int CLK_PS = 4000;
  localparam int PWR_PS = 400000;

  function automatic int cdiv(input int n, input int d);
    return (n + d - 1) / d;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_ADDR = 1;
  localparam int E_TURN = mx(cdiv(5000, CLK_PS), 1);
  localparam int E_DATA = mx(mx(cdiv(5500, CLK_PS), cdiv(7000, CLK_PS) - E_TURN),
                             mx(cdiv(10000, CLK_PS) - E_ADDR - E_TURN, 1));
  localparam int E_WR   = E_ADDR + E_TURN + E_DATA;
  localparam int E_RD   = cdiv(10000, CLK_PS) + 1;
  localparam int E_PWR  = cdiv(PWR_PS, CLK_PS);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, ce_n, ce, we_n, oe_n, dq_oe;
  logic [DW-1:0] rsp_rdata, dq_o, dq_i;
  logic [AW-1:0] maddr;

  always #2 clk = ~clk;

  sram_ctrl #(.CLK_PS(CLK_PS), .T_PWR_PS(PWR_PS)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .mem_ce_n_o(ce_n), .mem_ce_o(ce),
    .mem_we_n_o(we_n), .mem_oe_n_o(oe_n), .mem_addr_o(maddr), .mem_dq_o(dq_o),
    .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus model of the asynchronous memory, sampled away from the clock edge
  logic [DW-1:0] mem [int];
  bit            prev_wr = 0;
  logic [AW-1:0] prev_addr;
  logic [DW-1:0] prev_dq;
  int            turn_run = 0, data_run = 0;

  always @(negedge clk) begin
    if (!rst_ni) begin
      prev_wr = 0; turn_run = 0; data_run = 0; dq_i = 'x;
    end else begin
      bit sel, wr;
      sel = !ce_n && ce;
      wr  = sel && !we_n;
      if (dq_oe) chk(wr, "R4", "bus driven outside write", {we_n, sel}, 2'b01);
      if (wr && !dq_oe) turn_run++;
      if (wr && dq_oe)  data_run++;
      if (prev_wr && !wr) begin
        chk(turn_run >= E_TURN, "R4", "turnaround cycles", turn_run, E_TURN);
        chk(data_run >= E_DATA, "R4", "data setup cycles", data_run, E_DATA);
        mem[int'(prev_addr)] = prev_dq;
        turn_run = 0; data_run = 0;
      end
      prev_wr = wr; prev_addr = maddr; prev_dq = dq_o;
      if (sel && !oe_n && we_n && mem.exists(int'(maddr))) dq_i = mem[int'(maddr)];
      else dq_i = 'x;
    end
  end

  logic [AW-1:0] pool [16];
  logic [DW-1:0] expv [16];

  task automatic wait_accept();
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int lat;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    wait_accept();
    chk(!req_ready, "R8", "ready after write accept", req_ready, 0);
    lat = 0;
    while (!req_ready && lat < 50) begin
      bit ew, eo;
      ew = (lat >= E_ADDR);
      eo = (lat >= E_ADDR + E_TURN);
      chk(!ce_n && ce && (we_n == !ew) && (dq_oe == eo) && !oe_n && maddr == a &&
          (!eo || dq_o == d), "R3", "write phase pins",
          {ce_n, ce, we_n, oe_n, dq_oe}, {2'b01, !ew, 1'b0, eo});
      @(negedge clk);
      lat++;
    end
    chk(lat == E_WR, "R3", "write duration", lat, E_WR);
    chk(ce_n && !ce && we_n && !dq_oe, "R1", "idle after write",
        {ce_n, ce, we_n, dq_oe}, 4'b1010);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] e, input string req);
    int lat;
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    wait_accept();
    chk(!req_ready, "R8", "ready after read accept", req_ready, 0);
    lat = 0;
    while (!rsp_valid && lat < 50) begin
      chk(!ce_n && ce && we_n && !oe_n && !dq_oe && maddr == a, "R6", "read phase pins",
          {ce_n, ce, we_n, oe_n, dq_oe}, 5'b01100);
      @(negedge clk);
      lat++;
    end
    chk(lat == E_RD, "R6", "read latency", lat, E_RD);
    chk(rsp_rdata === e, req, "read data", rsp_rdata, e);
    @(negedge clk);
    chk(!rsp_valid, "R6", "valid pulse width", rsp_valid, 0);
  endtask

  task automatic power_up();
    int lat;
    bit bad;
    lat = 0; bad = 0;
    rst_ni = 1'b1;
    while (!req_ready && lat < E_PWR + 10) begin
      if (!ce_n || ce || !we_n || dq_oe) bad = 1;
      @(negedge clk);
      lat++;
    end
    chk(lat == E_PWR, "R2", "power-up lockout cycles", lat, E_PWR);
    chk(!bad, "R2", "deselected during power-up", bad, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5a17));
    repeat (3) @(negedge clk);
    chk(ce_n && !ce && we_n && !dq_oe && !req_ready && !rsp_valid, "R1", "reset state",
        {ce_n, ce, we_n, dq_oe, req_ready}, 5'b10100);
    power_up();

    pool[0] = '0;
    pool[1] = '1;
    pool[2] = 21'h155555;
    pool[3] = 21'h0aaaaa;
    for (int i = 4; i < 16; i++) pool[i] = AW'($urandom);
    for (int i = 0; i < 16; i++) begin
      expv[i] = DW'($urandom);
      do_write(pool[i], expv[i]);
    end
    do_read(pool[0], expv[0], "R10");
    do_read(pool[1], expv[1], "R10");
    for (int i = 2; i < 16; i++) do_read(pool[i], expv[i], "R5");
    expv[1] = 8'h00; do_write(pool[1], expv[1]); do_read(pool[1], expv[1], "R5");
    expv[0] = 8'hff; do_write(pool[0], expv[0]); do_read(pool[0], expv[0], "R5");

    for (int n = 0; n < 400; n++) begin
      int idx, gap;
      idx = int'($urandom % 16);
      gap = int'($urandom % 4);
      if ($urandom % 2) begin
        expv[idx] = DW'($urandom);
        do_write(pool[idx], expv[idx]);
      end else begin
        do_read(pool[idx], expv[idx], "R5");
      end
      repeat (gap) @(negedge clk);
    end

    // reset one clock into a write, before write enable falls
    req_valid = 1'b1; req_write = 1'b1; req_addr = pool[2]; req_wdata = ~expv[2];
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 rst_ni = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    chk(ce_n && !ce && we_n && !dq_oe && !req_ready, "R9", "pins under reset",
        {ce_n, ce, we_n, dq_oe, req_ready}, 5'b10100);
    @(negedge clk);
    power_up();
    do_read(pool[2], expv[2], "R9");
    do_read(pool[1], expv[1], "R10");

    finish_run();
  end
endmodule